// File: doc/BRIEF.md
# Audio DMA Two-Entry Request Queue

This block is the register front end of an audio output DMA engine. Software first writes a memory address and then a length. The length write pushes the pair {address, length} into a two-slot ping-pong queue. The entry at the head of the queue is presented to a downstream sample fetcher. The fetcher pulses `done` when it has finished that entry. The block then retires the head entry, raises an interrupt and moves on to the second entry if there is one.

Software sees the queue through a status word. In that word, bits 31 and 0 both mean "two entries held" and bit 30 means "engine busy". The engine starts by itself only when it was idle before the push. A length write made while both slots are occupied is dropped without any effect.

The block also holds a 14-bit sample-rate divider and a 4-bit bit-rate setting. From the divider it produces a sample strobe once every divider-plus-one clocks. It also drives the bit-rate value to the audio back end.

Top module: `aud_dma_queue`

## Requirements
- R1: After reset there is no entry on the output (`cur_valid`=0), `irq`=0, the status word reads 0, the divider reads 0 and `bit_rate`=0.
- R2: A write to the address register (select 0) stores `wr_data & 0x00FFFFF8`, and that value reads back at select 0.
- R3: A length write (select 1) that is accepted stores `wr_data & 0x0003FFF8`, which reads back at select 1, and pushes the current address register together with that length.
- R4: A length write while the queue is empty presents the pushed address and length on `cur_addr`/`cur_len` with `cur_valid`=1 from the next cycle.
- R5: The status word (select 2) has bit 30 set while any entry is held, and bits 31 and 0 set while two entries are held. All other bits read 0.
- R6: A length write while two entries are held changes nothing: not the queue contents, not the output and not the length readback.
- R7: A `done` pulse while `cur_valid`=1 retires the head entry, clears the full bits and sets `irq` on the next cycle. If a second entry is held, that entry is presented from the next cycle.
- R8: Retiring the last entry clears `cur_valid` and status bit 30. A `done` pulse while idle has no effect and raises no interrupt.
- R9: Any write to the status select clears `irq`. A retire in the same cycle wins, so `irq` stays set.
- R10: A length write and a retire in the same cycle keep the entry count unchanged, and the pushed entry is presented after the head.
- R11: The divider register (select 3) keeps bits 13:0. The bit-rate register (select 4) keeps bits 3:0 and drives `bit_rate`.
- R12: `sample_tick` pulses once every (divider + 1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes: 0 address, 1 length, 2 status, 3 divider, 4 bit rate |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data, registered, one cycle after `rd_sel` |
| cur_valid | output | 1 | Head entry is valid (engine busy) |
| cur_addr | output | 24 | Head entry memory address |
| cur_len | output | 18 | Head entry length |
| done | input | 1 | Consumer finished the head entry |
| irq | output | 1 | Audio interrupt, level |
| bit_rate | output | 4 | Bit-rate setting |
| sample_tick | output | 1 | Sample-rate strobe |

## Verification
A wrong entry count or wrong queue indices show up at the ports within one cycle of the next push or retire. The output then shows the wrong descriptor, or shows it in the wrong order, or `cur_valid` drops early or stays set after the last retire. The scoreboard catches each of these when `done` is pulsed. A full flag that is stuck or missing shows in the status readback, and it also shows later as an extra or missing descriptor. Wrong `irq` set or clear priority is visible on the cycle after a `done` or a status write.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd0;
  localparam logic [SEL_W-1:0] SEL_LEN  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RATE = 3'd3;
  localparam logic [SEL_W-1:0] SEL_BITS = 3'd4;
  // status word bit positions
  localparam int ST_FULL_HI = 31;
  localparam int ST_BUSY    = 30;
  localparam int ST_FULL_LO = 0;
  // low address/length bits forced to zero (8-byte granularity)
  localparam int ALIGN_BITS = 3;
endpackage

// File: rtl/aud_desc_store.sv
module aud_desc_store #(
  parameter int AW = 24,
  parameter int LW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  output logic [AW-1:0] head_addr,
  output logic [LW-1:0] head_len
);
  localparam int SLOTS = 2;
  localparam int EW    = AW + LW;

  logic [EW-1:0] slot_mem [SLOTS];
  logic          wr_ptr;
  logic          rd_ptr;

  // storage: no reset, plain indexed write
  always_ff @(posedge clk) begin
    if (push) slot_mem[wr_ptr] <= {in_addr, in_len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
    end else begin
      if (push) wr_ptr <= ~wr_ptr;
      if (pop)  rd_ptr <= ~rd_ptr;
    end
  end

  assign {head_addr, head_len} = slot_mem[rd_ptr];
endmodule

// File: rtl/aud_q_ctrl.sv
module aud_q_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic push_req,
  input  logic done,
  input  logic irq_ack,
  output logic push_ok,
  output logic pop,
  output logic full,
  output logic busy,
  output logic irq
);
  logic [1:0] count_q;
  logic [1:0] count_n;

  assign push_ok = push_req && !full;
  assign pop     = done && busy;

  always_comb begin
    count_n = count_q;
    if (push_ok && !pop)      count_n = count_q + 2'd1;
    else if (pop && !push_ok) count_n = count_q - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= 2'd0;
      full    <= 1'b0;
      busy    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      count_q <= count_n;
      full    <= (count_n == 2'd2);
      busy    <= (count_n != 2'd0);
      if (pop)          irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_rate_gen.sv
module aud_rate_gen #(
  parameter int RW = 14,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate_we,
  input  logic [RW-1:0] rate_in,
  input  logic          bits_we,
  input  logic [BW-1:0] bits_in,
  output logic [RW-1:0] rate_q,
  output logic [BW-1:0] bits_q,
  output logic          tick
);
  logic [RW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= '0;
      bits_q  <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      if (bits_we) bits_q <= bits_in;
      if (rate_we) begin
        rate_q  <= rate_in;
        div_cnt <= '0;
        tick    <= 1'b0;
      end else if (div_cnt == rate_q) begin
        div_cnt <= '0;
        tick    <= 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
        tick    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_dma_queue.sv
module aud_dma_queue
  import aud_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 24,
  parameter int LW = 18,
  parameter int RW = 14,
  parameter int BW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             cur_valid,
  output logic [AW-1:0]    cur_addr,
  output logic [LW-1:0]    cur_len,
  input  logic             done,
  output logic             irq,
  output logic [BW-1:0]    bit_rate,
  output logic             sample_tick
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_in;
  logic          len_wr, push_ok, pop, q_full, q_busy;
  logic [RW-1:0] rate_q;
  logic [DW-1:0] status_w;
  wire           unused_hi = &wr_data[DW-1:AW];

  assign len_wr = wr_en && (wr_sel == SEL_LEN);
  assign len_in = {wr_data[LW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_ADDR)
        addr_q <= {wr_data[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (push_ok) len_q <= len_in;
    end
  end

  aud_q_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_req (len_wr),
    .done     (done),
    .irq_ack  (wr_en && wr_sel == SEL_STAT),
    .push_ok  (push_ok),
    .pop      (pop),
    .full     (q_full),
    .busy     (q_busy),
    .irq      (irq)
  );

  aud_desc_store #(.AW(AW), .LW(LW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push_ok),
    .pop       (pop),
    .in_addr   (addr_q),
    .in_len    (len_in),
    .head_addr (cur_addr),
    .head_len  (cur_len)
  );

  aud_rate_gen #(.RW(RW), .BW(BW)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .rate_we (wr_en && wr_sel == SEL_RATE),
    .rate_in (wr_data[RW-1:0]),
    .bits_we (wr_en && wr_sel == SEL_BITS),
    .bits_in (wr_data[BW-1:0]),
    .rate_q  (rate_q),
    .bits_q  (bit_rate),
    .tick    (sample_tick)
  );

  assign cur_valid = q_busy;

  always_comb begin
    status_w             = '0;
    status_w[ST_FULL_HI] = q_full;
    status_w[ST_BUSY]    = q_busy;
    status_w[ST_FULL_LO] = q_full;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_sel)
        SEL_ADDR: rd_data <= DW'(addr_q);
        SEL_LEN:  rd_data <= DW'(len_q);
        SEL_STAT: rd_data <= status_w;
        SEL_RATE: rd_data <= DW'(rate_q);
        SEL_BITS: rd_data <= DW'(bit_rate);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/aud_dma_checker.sv
module aud_dma_checker
  import aud_dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic             done,
  input logic             cur_valid,
  input logic [AW-1:0]    cur_addr,
  input logic [LW-1:0]    cur_len,
  input logic             irq,
  input logic             q_full
);
  logic len_wr, stat_wr, retire;
  assign len_wr  = wr_en && wr_sel == SEL_LEN;
  assign stat_wr = wr_en && wr_sel == SEL_STAT;
  assign retire  = done && cur_valid;

  AST_START_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
    (!cur_valid && len_wr) |=> cur_valid); // R4
  AST_FULL_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
    q_full |-> cur_valid); // R5
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (q_full && len_wr && !done) |=> ($stable(cur_addr) && $stable(cur_len) && q_full)); // R6
  AST_IRQ_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
    retire |=> irq); // R7
  AST_LAST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (retire && !q_full && !len_wr) |=> !cur_valid); // R8
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!cur_valid && !irq) |=> !irq); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !retire) |=> !irq); // R9
endmodule

bind aud_dma_queue aud_dma_checker #(.AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .done      (done),
  .cur_valid (cur_valid),
  .cur_addr  (cur_addr),
  .cur_len   (cur_len),
  .irq       (irq),
  .q_full    (q_full)
);

// File: tb/test_aud_dma_queue.sv
`timescale 1ns/1ps
module test_aud_dma_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        cur_valid;
  logic [23:0] cur_addr;
  logic [17:0] cur_len;
  logic        done = 1'b0;
  logic        irq;
  logic [3:0]  bit_rate;
  logic        sample_tick;

  int checks = 0;
  int fails  = 0;
  int mcount = 0;
  logic [23:0] maddr = '0;
  logic [41:0] exp_q[$];

  always #10 clk = ~clk;

  aud_dma_queue i_aud_dma_queue (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cur_valid(cur_valid),
    .cur_addr(cur_addr), .cur_len(cur_len), .done(done), .irq(irq),
    .bit_rate(bit_rate), .sample_tick(sample_tick)
  );

  task automatic chk(input string req, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares the presented entry against the scoreboard on each retire
  always @(negedge clk) begin
    if (!rst && done && cur_valid) begin
      if (exp_q.size() == 0) chk("R7 unexpected entry", {cur_addr, cur_len}, '1);
      else chk("R4/R7 scoreboard entry", {cur_addr, cur_len}, exp_q.pop_front());
      mcount--;
    end
  end

  // tasks start and end just after a rising edge
  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    if (s == 3'd0) maddr = d[23:0] & 24'hFFFFF8;
    if (s == 3'd1 && mcount < 2) begin
      exp_q.push_back({maddr, d[17:0] & 18'h3FFF8});
      mcount++;
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    rd_sel = s;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(posedge clk); #1;
    done = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int gap;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 cur_valid", cur_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 bit_rate", bit_rate, 0);
    rd(3'd2, v); chk("R1 status", v, 0);
    rd(3'd3, v); chk("R1 divider", v, 0);
    // R2 address masking
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 addr readback", v, 32'h00FF_FFF8);
    // R3 / R4 first push starts idle engine
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R4 cur_valid after push", cur_valid, 1);
    chk("R4 cur_addr", cur_addr, 24'hFFFFF8);
    chk("R4 cur_len", cur_len, 18'h3FFF8);
    rd(3'd1, v); chk("R3 len readback", v, 32'h0003_FFF8);
    rd(3'd2, v); chk("R5 status one entry", v, 32'h4000_0000);
    // second entry -> full
    wr(3'd0, 32'h0012_3457);
    wr(3'd1, 32'h0000_1001);
    rd(3'd2, v); chk("R5 status full", v, 32'hC000_0001);
    chk("R4 head unchanged by second push", cur_addr, 24'hFFFFF8);
    // R6 push while full dropped
    wr(3'd0, 32'h00AB_CDE8);
    wr(3'd1, 32'h0000_2000);
    rd(3'd1, v); chk("R6 len readback unchanged", v, 32'h0000_1000);
    chk("R6 head unchanged", cur_addr, 24'hFFFFF8);
    rd(3'd2, v); chk("R6 still full", v, 32'hC000_0001);
    // R7 retire head
    pulse_done();
    chk("R7 irq set", irq, 1);
    chk("R7 next entry addr", cur_addr, 24'h123450);
    chk("R7 next entry len", cur_len, 18'h01000);
    rd(3'd2, v); chk("R7 full cleared", v, 32'h4000_0000);
    // R9 status write acknowledges
    wr(3'd2, 32'h0);
    chk("R9 irq cleared", irq, 0);
    // R10 push and retire together
    wr(3'd0, 32'h0000_0100);
    done = 1'b1;
    wr(3'd1, 32'h0000_0040);
    done = 1'b0;
    rd(3'd2, v); chk("R10 count unchanged", v, 32'h4000_0000);
    chk("R10 pushed entry next", cur_addr, 24'h000100);
    chk("R10 pushed len", cur_len, 18'h00040);
    // R8 retire last entry
    pulse_done();
    chk("R8 cur_valid cleared", cur_valid, 0);
    rd(3'd2, v); chk("R8 status idle", v, 32'h0);
    wr(3'd2, 32'h0);
    pulse_done();
    chk("R8 idle done no irq", irq, 0);
    chk("R8 idle done still idle", cur_valid, 0);
    // R9 retire beats acknowledge
    wr(3'd0, 32'h0000_0800);
    wr(3'd1, 32'h0000_0008);
    done = 1'b1;
    wr(3'd2, 32'h0);
    done = 1'b0;
    chk("R9 retire wins over ack", irq, 1);
    // R11 divider and bit rate
    wr(3'd3, 32'h0000_FFFF);
    rd(3'd3, v); chk("R11 divider masked", v, 32'h0000_3FFF);
    wr(3'd4, 32'h0000_00FF);
    rd(3'd4, v); chk("R11 bit rate masked", v, 32'h0000_000F);
    chk("R11 bit_rate port", bit_rate, 4'hF);
    // R12 tick period = divider + 1
    wr(3'd3, 32'd4);
    while (!sample_tick) begin @(posedge clk); #1; end
    gap = 0;
    do begin @(posedge clk); #1; gap++; end while (!sample_tick && gap < 100);
    chk("R12 tick period", gap, 5);
    chk("R7 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule